// File: doc/BRIEF.md
# Background Run-Length Map Encoder

This block sorts the regions of one image tile into moving and still regions. It then records where the moving regions are in a short list of byte-wide gap values. The input is a stream with one flow vector (du, dv) per region, given in row order. The encoder adds the absolute values of the two components and compares the sum with a programmable threshold. A region whose sum is below the threshold counts as background. Background regions only lengthen the current run. A foreground region closes the run: its length is written into the next free slot of the map.

The map is filled in a pass run once per tile. That pass comes after the first round of solver iterations and before the second round, which visits only foreground regions. A later fetch stage can rebuild each foreground position from the gaps. A zero entry marks the end of each row, and a reserved code covers runs of background too long for one byte. A `start` pulse prepares the encoder for the next tile.

Top module: `bgd_distmap_enc`

## Requirements
- R1: The magnitude of a region is |du|+|dv|, with du and dv in two's complement. A region is foreground when the magnitude is greater than or equal to `thresh` (unsigned), and background when it is lower.
- R2: A foreground region writes one entry equal to the number of background regions seen since the previous entry, plus one. The run count then returns to zero.
- R3: Each background region adds one to the run count. When a run reaches 254 background regions, the encoder writes the code 255 and the count restarts from zero. As a result, foreground entries always lie in 1..254.
- R4: A region marked `in_row_end` or `in_last` writes a 0 entry after any entry the region itself produces, and the run count is cleared.
- R5: Entries fill slots 0, 1, 2, ... in the order they are produced. Slot i appears on `map_flat[8*i+7:8*i]`, and `entry_count` gives the number of slots filled.
- R6: When all 20 slots are filled, `map_full` is high. Further writes are dropped, and the contents of the map and `entry_count` stay as they are.
- R7: A `start` pulse synchronously clears every slot, `entry_count`, `map_full`, `tile_done` and the run count. It takes precedence over a region presented in the same cycle.
- R8: Cycles with `in_valid` low change nothing, whatever the other inputs carry.
- R9: Outputs are registered: a region accepted at a clock edge is visible after that edge. `tile_done` goes high after the edge that accepts the region marked `in_last`.
- R10: After reset, all slots, `entry_count`, `map_full` and `tile_done` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears the encoder for a new tile |
| in_valid | input | 1 | A region is presented this cycle |
| in_du | input | 12 | Horizontal flow component, signed |
| in_dv | input | 12 | Vertical flow component, signed |
| in_row_end | input | 1 | Region is the last one in its row |
| in_last | input | 1 | Region is the last one in the tile |
| thresh | input | 13 | Foreground threshold, unsigned |
| map_flat | output | 160 | The 20 map slots, slot i in bits 8i+7..8i |
| entry_count | output | 5 | Number of slots filled |
| map_full | output | 1 | All slots filled |
| tile_done | output | 1 | Last region of the tile accepted |

## Verification
Full sweeps of du and dv over -6..6 are run at several thresholds. A magnitude exactly equal to the threshold must count as foreground, so a strict-versus-inclusive compare error changes entries. A sign error in the absolute value, for example at -2048, changes them as well. Long background runs of 253, 254 and 600 regions probe the saturation point: an off-by-one there gives 254 where 255 is expected, or leaves a stray count. Rows that end on a foreground region need two writes in one cycle, so a design that loses the second write drops the row marker. Dense tiles drive the map past 20 entries; a design without the guard would overwrite or wrap the last slots. Idle cycles carry arbitrary data, which catches any logic that looks at the data without the valid flag.

// File: rtl/bgd_pkg.sv
package bgd_pkg;
  // Sum of absolute values, the square-root-free magnitude estimate.
  function automatic int unsigned abs_sum(input int du, input int dv);
    int unsigned a;
    int unsigned b;
    a = (du < 0) ? int'(-du) : int'(du);
    b = (dv < 0) ? int'(-dv) : int'(dv);
    return a + b;
  endfunction

  // Entry value for a foreground region closing a run of length run_len.
  function automatic int unsigned fg_code(input int unsigned run_len);
    return run_len + 1;
  endfunction
endpackage

// File: rtl/bgd_classifier.sv
module bgd_classifier #(
  parameter int FLOW_W = 12,
  localparam int MAG_W = FLOW_W + 1
) (
  input  logic signed [FLOW_W-1:0] du,
  input  logic signed [FLOW_W-1:0] dv,
  input  logic        [MAG_W-1:0]  thresh,
  output logic        [MAG_W-1:0]  mag,
  output logic                     fg
);
  always_comb begin
    mag = MAG_W'(bgd_pkg::abs_sum(int'(du), int'(dv)));
    fg  = (mag >= thresh);
  end
endmodule

// File: rtl/bgd_run_counter.sv
module bgd_run_counter #(
  parameter int ENTRY_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               valid,
  input  logic               fg,
  input  logic               eor,
  output logic               w0_en,
  output logic [ENTRY_W-1:0] w0_data,
  output logic               w1_en,
  output logic [ENTRY_W-1:0] w1_data,
  output logic               force_wr,
  output logic [ENTRY_W-1:0] cnt_q
);
  localparam logic [ENTRY_W-1:0] SAT  = ENTRY_W'((1 << ENTRY_W) - 2);
  localparam logic [ENTRY_W-1:0] SKIP = ENTRY_W'((1 << ENTRY_W) - 1);

  logic [ENTRY_W-1:0] cnt_d;

  always_comb begin
    w0_en    = 1'b0;
    w0_data  = '0;
    w1_en    = 1'b0;
    w1_data  = '0;
    force_wr = 1'b0;
    cnt_d    = cnt_q;
    if (valid) begin
      if (fg) begin
        w0_en   = 1'b1;
        w0_data = ENTRY_W'(bgd_pkg::fg_code(32'(cnt_q)));
        cnt_d   = '0;
      end else if (cnt_q == SAT - ENTRY_W'(1)) begin
        w0_en    = 1'b1;
        w0_data  = SKIP;
        force_wr = 1'b1;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_q + ENTRY_W'(1);
      end
      if (eor) begin
        if (w0_en) w1_en = 1'b1;
        else       w0_en = 1'b1;
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else          cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bgd_map_regs.sv
module bgd_map_regs #(
  parameter int DEPTH   = 20,
  parameter int ENTRY_W = 8,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       w0_en,
  input  logic [ENTRY_W-1:0]         w0_data,
  input  logic                       w1_en,
  input  logic [ENTRY_W-1:0]         w1_data,
  output logic [DEPTH*ENTRY_W-1:0]   map_flat,
  output logic [CNT_W-1:0]           count,
  output logic                       full
);
  logic [CNT_W:0] idx0;
  logic [CNT_W:0] idx1;
  logic           acc0;
  logic           acc1;

  always_comb begin
    idx0 = {1'b0, count};
    idx1 = idx0 + (CNT_W+1)'(1);
    acc0 = w0_en && (idx0 < (CNT_W+1)'(DEPTH));
    acc1 = w0_en && w1_en && (idx1 < (CNT_W+1)'(DEPTH));
    full = (idx0 == (CNT_W+1)'(DEPTH));
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [ENTRY_W-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  slot_q <= '0;
      else if (clr)                                slot_q <= '0;
      else if (acc0 && idx0 == (CNT_W+1)'(i))      slot_q <= w0_data;
      else if (acc1 && idx1 == (CNT_W+1)'(i))      slot_q <= w1_data;
    end
    assign map_flat[i*ENTRY_W +: ENTRY_W] = slot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else          count <= count + CNT_W'(acc0) + CNT_W'(acc1);
  end
endmodule

// File: rtl/bgd_distmap_enc.sv
module bgd_distmap_enc #(
  parameter int FLOW_W  = 12,
  parameter int DEPTH   = 20,
  parameter int ENTRY_W = 8,
  localparam int MAG_W  = FLOW_W + 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      in_valid,
  input  logic signed [FLOW_W-1:0]  in_du,
  input  logic signed [FLOW_W-1:0]  in_dv,
  input  logic                      in_row_end,
  input  logic                      in_last,
  input  logic [MAG_W-1:0]          thresh,
  output logic [DEPTH*ENTRY_W-1:0]  map_flat,
  output logic [CNT_W-1:0]          entry_count,
  output logic                      map_full,
  output logic                      tile_done
);
  // Named internal events, visible to the bound checker.
  logic               ev_fg;
  logic               ev_eor;
  logic               ev_take;
  logic               ev_force;
  logic [MAG_W-1:0]   mag;
  logic               w0_en;
  logic               w1_en;
  logic [ENTRY_W-1:0] w0_data;
  logic [ENTRY_W-1:0] w1_data;
  logic [ENTRY_W-1:0] run_cnt;

  assign ev_eor  = in_row_end | in_last;
  assign ev_take = in_valid & ~start;

  bgd_classifier #(.FLOW_W(FLOW_W)) u_cls (
    .du(in_du), .dv(in_dv), .thresh(thresh), .mag(mag), .fg(ev_fg)
  );

  bgd_run_counter #(.ENTRY_W(ENTRY_W)) u_run (
    .clk(clk), .rst_n(rst_n), .clr(start), .valid(ev_take), .fg(ev_fg),
    .eor(ev_eor), .w0_en(w0_en), .w0_data(w0_data), .w1_en(w1_en),
    .w1_data(w1_data), .force_wr(ev_force), .cnt_q(run_cnt)
  );

  bgd_map_regs #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_map (
    .clk(clk), .rst_n(rst_n), .clr(start), .w0_en(w0_en), .w0_data(w0_data),
    .w1_en(w1_en), .w1_data(w1_data), .map_flat(map_flat),
    .count(entry_count), .full(map_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  tile_done <= 1'b0;
    else if (start)              tile_done <= 1'b0;
    else if (in_valid & in_last) tile_done <= 1'b1;
  end
endmodule

// File: rtl/bgd_distmap_chk.sv
module bgd_distmap_chk #(
  parameter int DEPTH   = 20,
  parameter int ENTRY_W = 8,
  parameter int CNT_W   = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start,
  input logic                     in_valid,
  input logic                     ev_fg,
  input logic                     ev_eor,
  input logic                     map_full,
  input logic [CNT_W-1:0]         entry_count,
  input logic [DEPTH*ENTRY_W-1:0] map_flat,
  input logic [ENTRY_W-1:0]       run_cnt
);
  a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    32'(entry_count) <= DEPTH);

  a_r6_full_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (map_full && !start) |=> ($stable(map_flat) && $stable(entry_count)));

  a_r5_count_grows: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> entry_count >= $past(entry_count));

  a_r2_fg_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ev_fg && !map_full && !start) |=> entry_count != $past(entry_count));

  a_r4_row_end_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ev_eor && !map_full && !start) |=> (entry_count != $past(entry_count) && run_cnt == '0));

  a_r3_run_below_sat: assert property (@(posedge clk) disable iff (!rst_n)
    32'(run_cnt) < (1 << ENTRY_W) - 2);

  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !start) |=> ($stable(map_flat) && $stable(run_cnt)));

  a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (entry_count == '0 && !map_full && run_cnt == '0));
endmodule

bind bgd_distmap_enc bgd_distmap_chk #(
  .DEPTH(DEPTH), .ENTRY_W(ENTRY_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
  .ev_fg(ev_fg), .ev_eor(ev_eor), .map_full(map_full),
  .entry_count(entry_count), .map_flat(map_flat), .run_cnt(run_cnt)
);

// File: tb/sim_bgd_distmap_enc.sv
`timescale 1ns/1ps
module sim_bgd_distmap_enc;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start = 1'b0;
  logic               in_valid = 1'b0;
  logic signed [11:0] in_du = '0;
  logic signed [11:0] in_dv = '0;
  logic               in_row_end = 1'b0;
  logic               in_last = 1'b0;
  logic [12:0]        thresh = '0;
  logic [159:0]       map_flat;
  logic [4:0]         entry_count;
  logic               map_full;
  logic               tile_done;

  bgd_distmap_enc u0 (.*);

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  int exp_map[20];
  int exp_n;
  int bg_run;
  bit exp_done;

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 20; i++) exp_map[i] = 0;
    exp_n = 0; bg_run = 0; exp_done = 0;
  endtask

  task automatic push(input int v);
    if (exp_n < 20) begin
      exp_map[exp_n] = v;
      exp_n++;
    end
  endtask

  task automatic compare(input string req);
    for (int i = 0; i < 20; i++)
      check(int'(map_flat[8*i +: 8]) == exp_map[i], {req, " R5 slot"},
            int'(map_flat[8*i +: 8]), exp_map[i]);
    check(int'(entry_count) == exp_n, {req, " R5 count"}, int'(entry_count), exp_n);
    check(map_full == (exp_n == 20), {req, " R6 full"}, int'(map_full), int'(exp_n == 20));
    check(tile_done == exp_done, {req, " R9 done"}, int'(tile_done), int'(exp_done));
  endtask

  task automatic do_start();
    start = 1'b1;
    in_valid = 1'b1; in_du = 12'sd100; in_row_end = 1'b1;
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0; in_row_end = 1'b0;
    model_clear();
  endtask

  // One region; the model restates R1..R4 with plain integers.
  task automatic send(input int du, input int dv, input bit re, input bit last);
    int a;
    int b;
    in_valid = 1'b1; in_du = 12'(du); in_dv = 12'(dv);
    in_row_end = re; in_last = last;
    @(negedge clk);
    in_valid = 1'b0; in_row_end = 1'b0; in_last = 1'b0;
    a = du; if (a < 0) a = 0 - a;
    b = dv; if (b < 0) b = 0 - b;
    if (a + b >= int'(thresh)) begin
      push(bg_run + 1); bg_run = 0;
    end else begin
      bg_run++;
      if (bg_run == 254) begin push(255); bg_run = 0; end
    end
    if (re || last) begin push(0); bg_run = 0; end
    if (last) exp_done = 1;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      in_valid = 1'b0; in_du = 12'(k * 37 - 900); in_dv = 12'(k * 5);
      in_row_end = k[0]; in_last = k[1];
      @(negedge clk);
    end
    in_row_end = 1'b0; in_last = 1'b0;
  endtask

  task automatic sweep(input int thr, input string req);
    do_start();
    thresh = 13'(thr);
    for (int du = -6; du <= 6; du++)
      for (int dv = -6; dv <= 6; dv++) begin
        send(du, dv, dv == 6, (du == 6) && (dv == 6));
        if (dv == 0) idle(1);
      end
    compare(req);
  endtask

  initial begin
    model_clear();
    repeat (2) @(negedge clk);
    compare("R10 reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R4 R8: sweeps of the component plane at several thresholds
    sweep(0,  "R1 thr0");
    sweep(4,  "R1 thr4");
    sweep(9,  "R1 R2 thr9");
    sweep(13, "R4 thr13");

    // R3: run lengths at and around saturation
    do_start();
    thresh = 13'd10;
    for (int k = 0; k < 253; k++) send(1, 2, 0, 0);
    send(5, 5, 0, 0);
    for (int k = 0; k < 600; k++) send(-3, 3, 0, 0);
    idle(3);
    send(-7, 3, 0, 0);
    send(0, 0, 0, 1);
    compare("R3 saturation");

    // R1 extremes, R4 two writes in one cycle
    do_start();
    thresh = 13'd4096;
    send(-2048, -2048, 0, 0);
    send(2047, 2048 - 1, 0, 0);
    thresh = 13'd4095;
    send(2047, 2047, 1, 0);
    thresh = 13'd4097;
    send(-2048, -2048, 1, 0);
    thresh = 13'd5;
    send(-5, 0, 1, 0);
    send(0, -4, 0, 1);
    compare("R1 R4 extremes");

    // R6 overflow, then R7 restart in the same cycle as a region
    do_start();
    thresh = 13'd1;
    for (int k = 0; k < 30; k++) send(1, 0, k % 7 == 6, 0);
    compare("R6 overflow");
    do_start();
    compare("R7 start");
    send(0, 0, 0, 0);
    send(3, 0, 0, 1);
    compare("R7 R9 after start");

    finished = 1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule